// File: doc/BRIEF.md
# Three-stage instruction pipeline with decode-time address formation

This block is a small fetch, decode and execute pipeline for a toy DSP-style instruction set. It holds eight address registers, a four-bit condition register and a one-bit memory-map mode. Each instruction cycle lasts four clocks, and every stage advances on the last of those four clocks. Indirect memory operands are resolved in decode, but register, mode and condition writes only take effect at the end of execute. The pipeline has no interlock and no forwarding. A write by the instruction directly ahead is therefore invisible to an address formed behind it. Code that depends on the written value has to leave one instruction between the writer and the reader.

A program memory is read combinationally at `pmem_addr_o`, and a data memory is read during execute through an address plus a region flag. Each completed instruction is reported for one clock on a trace port. The report carries the operation, the effective address, the region and the data returned. A program word carries the opcode in bits 15:12. The register index sits in bits 11:9, the jump condition mask in bits 11:8 and the 8-bit immediate or jump target in bits 7:0.

Top module: `dpipe_core`

## Requirements
- R1: During reset `trace_valid_o` and `dmem_re_o` are 0 and `pmem_addr_o` is 0. All address registers, the map bit and the condition register clear to 0. The first instruction completes 12 clocks after reset release.
- R2: Consecutive one-word instructions complete exactly 4 clocks apart, and each `trace_valid_o` pulse lasts one clock.
- R3: The absolute load (opcode 3) takes a second word that holds the address in its low bits. It completes 8 clocks after the instruction before it, or 16 clocks after reset or a taken jump. The instruction after it completes 4 clocks later.
- R4: An indirect load (opcode 2, register in bits 11:9) uses the register value as it stood before the immediately preceding instruction. A load-register (opcode 1, value in bits 7:0) directly ahead is not seen.
- R5: With one instruction between a load-register and an indirect load through the same register, the load uses the new value.
- R6: A data access goes to the internal ROM (`dmem_ext_o`=0) only when the map bit is 1 and the address is below ROM_WORDS (128). Otherwise it goes to external RAM. An indirect load right after OR-to-mode (opcode 4, bit 0) uses the old map, and one NOP in between makes it use the new map.
- R7: OR-to-condition (opcode 6) and AND-to-condition (opcode 7) use imm bits 3:0. Their result is seen by a conditional jump that executes immediately after them. The jump is opcode 8 and is taken when the mask is 0 or when mask AND condition is nonzero.
- R8: A taken jump discards the two younger instructions and fetches from its 8-bit target. The target completes 12 clocks after the jump, and the discarded instructions leave no register effect.
- R9: The trace reports the opcode, address, region and data. Opcodes 9 to 15 run as NOP and report 0. Non-memory operations report address 0, region 0 and data 0.
- R10: The second decode cycle of an absolute load follows the execute of the preceding instruction, so the load uses a map bit set or cleared by that instruction. AND-to-mode is opcode 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pmem_addr_o | output | PC_W | Program memory read address |
| pmem_data_i | input | 16 | Program word at `pmem_addr_o` |
| dmem_re_o | output | 1 | Data read active in execute |
| dmem_addr_o | output | AW | Data read address |
| dmem_ext_o | output | 1 | Region: 1 external RAM, 0 internal ROM |
| dmem_data_i | input | 16 | Data returned for address and region |
| trace_valid_o | output | 1 | One-clock pulse per completed instruction |
| trace_op_o | output | 4 | Completed opcode |
| trace_addr_o | output | AW | Effective address |
| trace_ext_o | output | 1 | Region used |
| trace_data_o | output | 16 | Data read |

## Verification
The hardest case to reach from the ports is a stale read that interacts with pipeline bubbles. Examples are an absolute load behind a mode write, a one-word load behind an absolute load, and the instructions after a taken jump. Directed programs set up each ordering explicitly. Seeded random programs then mix all opcodes, invalid codes and jumps. A bench model applies the stale-view rule at the instruction level and predicts each address, region, data value and completion gap.

// File: rtl/dpipe_pkg.sv
package dpipe_pkg;
  localparam int WORD_W = 16;
  localparam int NREG   = 8;
  localparam int RSEL_W = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0, OP_LDI  = 4'd1, OP_LDX = 4'd2, OP_LDA  = 4'd3,
    OP_ORM  = 4'd4, OP_ANDM = 4'd5, OP_ORC = 4'd6, OP_ANDC = 4'd7,
    OP_JCC  = 4'd8
  } op_e;

  function automatic op_e decode_op(logic [3:0] raw);
    return (raw <= 4'd8) ? op_e'(raw) : OP_NOP;
  endfunction

  function automatic logic two_word(logic [3:0] raw);
    return raw == 4'd3;
  endfunction

  function automatic logic is_mem(op_e op);
    return (op == OP_LDX) || (op == OP_LDA);
  endfunction
endpackage

// File: rtl/dpipe_agu.sv
module dpipe_agu
  import dpipe_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ROM_WORDS = 128
) (
  input  logic [3:0]    raw_op_i,
  input  logic [AW-1:0] ext_i,
  input  logic [AW-1:0] rn_i,
  input  logic          map_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic          ext_o
);
  always_comb begin
    op_o = decode_op(raw_op_i);
    unique case (op_o)
      OP_LDX:  addr_o = rn_i;
      OP_LDA:  addr_o = ext_i;
      default: addr_o = '0;
    endcase
    // internal ROM only when mapped in and inside its window
    ext_o = is_mem(op_o) && !(map_i && (int'(addr_o) < ROM_WORDS));
  end
endmodule

// File: rtl/dpipe_state.sv
module dpipe_state
  import dpipe_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  op_e               op_i,
  input  logic [RSEL_W-1:0] wn_i,
  input  logic [7:0]        imm_i,
  input  logic [RSEL_W-1:0] rd_n_i,
  output logic [AW-1:0]     rn_o,
  output logic              map_o,
  output logic [3:0]        ccr_o
);
  logic [NREG-1:0][AW-1:0] ar_w;

  for (genvar g = 0; g < NREG; g++) begin : g_ar
    logic [AW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (we_i && op_i == OP_LDI && wn_i == RSEL_W'(g)) r_q <= AW'(imm_i);
    end
    assign ar_w[g] = r_q;
  end

  assign rn_o = ar_w[rd_n_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_o <= 1'b0;
      ccr_o <= '0;
    end else if (we_i) begin
      unique case (op_i)
        OP_ORM:  map_o <= map_o | imm_i[0];
        OP_ANDM: map_o <= map_o & imm_i[0];
        OP_ORC:  ccr_o <= ccr_o | imm_i[3:0];
        OP_ANDC: ccr_o <= ccr_o & imm_i[3:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dpipe_core.sv
module dpipe_core
  import dpipe_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int AW        = 8,
  parameter int ROM_WORDS = 128,
  parameter int PHASES    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   pmem_addr_o,
  input  logic [WORD_W-1:0] pmem_data_i,
  output logic              dmem_re_o,
  output logic [AW-1:0]     dmem_addr_o,
  output logic              dmem_ext_o,
  input  logic [WORD_W-1:0] dmem_data_i,
  output logic              trace_valid_o,
  output logic [3:0]        trace_op_o,
  output logic [AW-1:0]     trace_addr_o,
  output logic              trace_ext_o,
  output logic [WORD_W-1:0] trace_data_o
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PH_W-1:0]   ph_q;
  logic              tick;
  logic [PC_W-1:0]   pc_q;
  logic              d_valid_q, d_wait_q;
  logic [WORD_W-1:0] d_ir_q;
  logic [AW-1:0]     d_ext_q;
  logic              e_valid_q, e_ext_q;
  logic [WORD_W-1:0] e_ir_q;
  op_e               e_op_q;
  logic [AW-1:0]     e_addr_q;

  op_e               dec_op;
  logic [AW-1:0]     dec_addr, rn;
  logic              dec_ext, map, taken, flush;
  logic [3:0]        ccr;

  assign tick = (ph_q == PH_W'(PHASES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= tick ? '0 : ph_q + PH_W'(1);
  end

  dpipe_state #(.AW(AW)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tick && e_valid_q),
    .op_i   (e_op_q),
    .wn_i   (e_ir_q[11:9]),
    .imm_i  (e_ir_q[7:0]),
    .rd_n_i (d_ir_q[11:9]),
    .rn_o   (rn),
    .map_o  (map),
    .ccr_o  (ccr)
  );

  // address and region formed here, against state not yet updated by execute
  dpipe_agu #(.AW(AW), .ROM_WORDS(ROM_WORDS)) u_agu (
    .raw_op_i (d_ir_q[15:12]),
    .ext_i    (d_ext_q),
    .rn_i     (rn),
    .map_i    (map),
    .op_o     (dec_op),
    .addr_o   (dec_addr),
    .ext_o    (dec_ext)
  );

  assign taken = (e_op_q == OP_JCC) &&
                 ((e_ir_q[11:8] == 4'd0) || |(ccr & e_ir_q[11:8]));
  assign flush = e_valid_q && taken;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      d_valid_q <= 1'b0;
      d_wait_q  <= 1'b0;
      d_ir_q    <= '0;
      d_ext_q   <= '0;
      e_valid_q <= 1'b0;
      e_ir_q    <= '0;
      e_op_q    <= OP_NOP;
      e_addr_q  <= '0;
      e_ext_q   <= 1'b0;
    end else if (tick) begin
      if (flush) begin
        pc_q      <= PC_W'(e_ir_q[7:0]);
        d_valid_q <= 1'b0;
        d_wait_q  <= 1'b0;
        e_valid_q <= 1'b0;
      end else if (d_valid_q && d_wait_q) begin
        // second word fetched; execute gets a bubble
        d_ext_q   <= pmem_data_i[AW-1:0];
        d_wait_q  <= 1'b0;
        pc_q      <= pc_q + PC_W'(1);
        e_valid_q <= 1'b0;
      end else begin
        e_valid_q <= d_valid_q;
        e_ir_q    <= d_ir_q;
        e_op_q    <= dec_op;
        e_addr_q  <= dec_addr;
        e_ext_q   <= dec_ext;
        d_ir_q    <= pmem_data_i;
        d_valid_q <= 1'b1;
        d_wait_q  <= two_word(pmem_data_i[15:12]);
        pc_q      <= pc_q + PC_W'(1);
      end
    end
  end

  assign pmem_addr_o = pc_q;
  assign dmem_re_o   = e_valid_q && is_mem(e_op_q);
  assign dmem_addr_o = e_addr_q;
  assign dmem_ext_o  = e_ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_valid_o <= 1'b0;
      trace_op_o    <= '0;
      trace_addr_o  <= '0;
      trace_ext_o   <= 1'b0;
      trace_data_o  <= '0;
    end else begin
      trace_valid_o <= tick && e_valid_q;
      if (tick && e_valid_q) begin
        trace_op_o   <= e_op_q;
        trace_addr_o <= e_addr_q;
        trace_ext_o  <= e_ext_q;
        trace_data_o <= is_mem(e_op_q) ? dmem_data_i : '0;
      end
    end
  end

  // R2
  trace_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_valid_o |=> !trace_valid_o);

  // R6
  rom_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_re_o && !dmem_ext_o |-> int'(dmem_addr_o) < ROM_WORDS);

  // R9
  trace_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_valid_o && !(trace_op_o inside {4'd2, 4'd3}) |->
      trace_addr_o == '0 && trace_data_o == '0 && !trace_ext_o);

  // R8
  flush_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && flush |=> pmem_addr_o == $past(PC_W'(e_ir_q[7:0])));

  // R3
  two_word_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && d_valid_q && d_wait_q && !flush |=> !dmem_re_o);
endmodule

// File: tb/tb_dpipe_core.sv
`timescale 1ns/1ps
module tb_dpipe_core;
  localparam int NCAP = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pmem_addr_o;
  logic [15:0] pmem_data_i;
  logic        dmem_re_o;
  logic [7:0]  dmem_addr_o;
  logic        dmem_ext_o;
  logic [15:0] dmem_data_i;
  logic        trace_valid_o;
  logic [3:0]  trace_op_o;
  logic [7:0]  trace_addr_o;
  logic        trace_ext_o;
  logic [15:0] trace_data_o;

  always #4 clk = ~clk;

  logic [15:0] pmem [256];

  function automatic logic [15:0] dm(logic [7:0] a, logic e);
    return e ? {8'hE5, a} : {8'h3C, a};
  endfunction

  assign pmem_data_i = pmem[pmem_addr_o];
  assign dmem_data_i = dm(dmem_addr_o, dmem_ext_o);

  dpipe_core dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pmem_addr_o(pmem_addr_o), .pmem_data_i(pmem_data_i),
    .dmem_re_o(dmem_re_o), .dmem_addr_o(dmem_addr_o), .dmem_ext_o(dmem_ext_o),
    .dmem_data_i(dmem_data_i),
    .trace_valid_o(trace_valid_o), .trace_op_o(trace_op_o),
    .trace_addr_o(trace_addr_o), .trace_ext_o(trace_ext_o), .trace_data_o(trace_data_o)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, base = 0, cap_n = 0;
  bit cap_en = 0;
  logic [3:0]  cap_op [NCAP];
  logic [7:0]  cap_addr [NCAP];
  logic        cap_ext [NCAP];
  logic [15:0] cap_data [NCAP];
  int          cap_t [NCAP];
  logic [3:0]  exp_op [NCAP];
  logic [7:0]  exp_addr [NCAP];
  logic        exp_ext [NCAP];
  logic [15:0] exp_data [NCAP];
  int          exp_gap [NCAP];
  bit          exp_tw [NCAP];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (cap_en && trace_valid_o && cap_n < NCAP) begin
      cap_op[cap_n]   = trace_op_o;
      cap_addr[cap_n] = trace_addr_o;
      cap_ext[cap_n]  = trace_ext_o;
      cap_data[cap_n] = trace_data_o;
      cap_t[cap_n]    = cyc - base;
      cap_n++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) pmem[i] = 16'h0000;
  endtask

  task automatic run(int n);
    cap_en = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(trace_valid_o == 1'b0, "R1", "trace_valid in reset", trace_valid_o, 0);
    check(pmem_addr_o == 8'h00, "R1", "pc in reset", pmem_addr_o, 0);
    check(dmem_re_o == 1'b0, "R1", "dmem_re in reset", dmem_re_o, 0);
    rst_ni = 1'b1;
    base = cyc;
    cap_n = 0;
    cap_en = 1;
    for (int i = 0; i < 4000 && cap_n < n; i++) @(negedge clk);
    cap_en = 0;
    check(cap_n >= n, "R2", "retired count", cap_n, n);
  endtask

  // instruction-level model: one-word ops see state before the last retired op
  task automatic model(int n);
    logic [7:0] ar [8];
    logic [7:0] ar_o [8];
    logic map, map_o;
    logic [3:0] ccr;
    logic [7:0] pc;
    bit jumped;
    for (int i = 0; i < 8; i++) begin ar[i] = 0; ar_o[i] = 0; end
    map = 0; map_o = 0; ccr = 0; pc = 0; jumped = 1;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w, x;
      logic [3:0] op;
      logic [2:0] rn;
      logic [7:0] addr;
      logic vmap, mem, ext, tw, tk;
      w  = pmem[pc];
      x  = pmem[8'(pc + 8'd1)];
      op = (w[15:12] <= 4'd8) ? w[15:12] : 4'd0;
      rn = w[11:9];
      tw = (op == 4'd3);
      vmap = tw ? map : map_o;
      addr = (op == 4'd2) ? (tw ? ar[rn] : ar_o[rn]) : (op == 4'd3) ? x[7:0] : 8'h00;
      mem  = (op == 4'd2) || (op == 4'd3);
      ext  = mem && !(vmap && addr < 8'd128);
      exp_op[k]   = op;
      exp_addr[k] = addr;
      exp_ext[k]  = ext;
      exp_data[k] = mem ? dm(addr, ext) : 16'h0000;
      exp_gap[k]  = 4 + (tw ? 4 : 0) + (jumped ? 8 : 0);
      exp_tw[k]   = tw;
      ar_o = ar;
      map_o = map;
      tk = 0;
      case (op)
        4'd1: ar[rn] = w[7:0];
        4'd4: map = map | w[0];
        4'd5: map = map & w[0];
        4'd6: ccr = ccr | w[3:0];
        4'd7: ccr = ccr & w[3:0];
        4'd8: tk = (w[11:8] == 4'd0) || ((ccr & w[11:8]) != 4'd0);
        default: ;
      endcase
      pc = tk ? w[7:0] : 8'(pc + (tw ? 8'd2 : 8'd1));
      jumped = tk;
    end
  endtask

  task automatic compare(int n);
    model(n);
    for (int k = 0; k < n && k < cap_n; k++) begin
      int gap;
      gap = (k == 0) ? cap_t[0] : cap_t[k] - cap_t[k-1];
      check(cap_op[k] == exp_op[k], "R9", $sformatf("op[%0d]", k), cap_op[k], exp_op[k]);
      check(cap_addr[k] == exp_addr[k], "R4", $sformatf("addr[%0d]", k), cap_addr[k], exp_addr[k]);
      check(cap_ext[k] == exp_ext[k], "R6", $sformatf("region[%0d]", k), cap_ext[k], exp_ext[k]);
      check(cap_data[k] == exp_data[k], "R9", $sformatf("data[%0d]", k), cap_data[k], exp_data[k]);
      check(gap == exp_gap[k], exp_tw[k] ? "R3" : "R2", $sformatf("gap[%0d]", k), gap, exp_gap[k]);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cap_n, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // register hazard: R1 R4 R5
    clear_prog();
    pmem[0] = 16'h1410; pmem[1] = 16'h2400;
    pmem[2] = 16'h1620; pmem[3] = 16'h0000; pmem[4] = 16'h2600;
    run(5);
    check(cap_t[0] == 12, "R1", "first retire clock", cap_t[0], 12);
    check(cap_t[1] - cap_t[0] == 4, "R2", "back-to-back gap", cap_t[1] - cap_t[0], 4);
    check(cap_addr[1] == 8'h00, "R4", "stale Rn", cap_addr[1], 0);
    check(cap_addr[4] == 8'h20, "R5", "Rn after one gap", cap_addr[4], 8'h20);
    compare(5);

    // map hazard: R6 R10 R3
    clear_prog();
    pmem[0] = 16'h1205; pmem[1] = 16'h0000; pmem[2] = 16'h4001;
    pmem[3] = 16'h2200; pmem[4] = 16'h2200; pmem[5] = 16'h1890;
    pmem[6] = 16'h0000; pmem[7] = 16'h2800; pmem[8] = 16'h5000;
    pmem[9] = 16'h3000; pmem[10] = 16'h0030; pmem[11] = 16'h4001;
    pmem[12] = 16'h3000; pmem[13] = 16'h0031;
    run(12);
    check(cap_ext[3] == 1'b1, "R6", "old map after ORM", cap_ext[3], 1);
    check(cap_ext[4] == 1'b0, "R6", "new map after NOP", cap_ext[4], 0);
    check(cap_ext[7] == 1'b1, "R6", "above ROM window", cap_ext[7], 1);
    check(cap_ext[9] == 1'b1, "R10", "two-word sees cleared map", cap_ext[9], 1);
    check(cap_ext[11] == 1'b0, "R10", "two-word sees set map", cap_ext[11], 0);
    check(cap_t[9] - cap_t[8] == 8, "R3", "two-word gap", cap_t[9] - cap_t[8], 8);
    check(cap_t[10] - cap_t[9] == 4, "R3", "after two-word gap", cap_t[10] - cap_t[9], 4);
    compare(12);

    // condition and jump: R7 R8
    clear_prog();
    pmem[0] = 16'h7000; pmem[1] = 16'h6004; pmem[2] = 16'h8410;
    pmem[3] = 16'h1A77;
    pmem[16] = 16'h1C33; pmem[17] = 16'h0000; pmem[18] = 16'h2C00;
    pmem[19] = 16'h7000; pmem[20] = 16'h8420; pmem[21] = 16'h0000;
    pmem[22] = 16'h2A00;
    run(10);
    check(cap_t[3] - cap_t[2] == 12, "R8", "jump refill gap", cap_t[3] - cap_t[2], 12);
    check(cap_addr[5] == 8'h33, "R7", "taken path reached", cap_addr[5], 8'h33);
    check(cap_t[8] - cap_t[7] == 4, "R7", "not-taken falls through", cap_t[8] - cap_t[7], 4);
    check(cap_addr[9] == 8'h00, "R8", "flushed write absent", cap_addr[9], 0);
    compare(10);

    // seeded random programs
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 256; i++) begin
        logic [15:0] w;
        int sel;
        sel = $urandom % 10;
        w = 16'($urandom);
        case (sel)
          0:       w[15:12] = 4'd0;
          1, 2:    w[15:12] = 4'd1;
          3, 4:    w[15:12] = 4'd2;
          5:       w[15:12] = 4'd3;
          6:       w[15:12] = ($urandom % 2) ? 4'd4 : 4'd5;
          7:       w[15:12] = ($urandom % 2) ? 4'd6 : 4'd7;
          8:       w[15:12] = 4'd8;
          default: w[15:12] = 4'(9 + $urandom % 7);
        endcase
        pmem[i] = w;
      end
      run(40);
      compare(40);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule